// File: doc/BRIEF.md
# Infrared Link Interrupt Aggregator

This block gathers the event pulses of an infrared link controller into one interrupt line. The link can run in a slow asynchronous mode (SIR) or in one of two faster framed modes (MIR and FIR). A transfer-mode register holds a 2-bit mode field and three group mask bits. Two event banks hold the pending events. One bank serves SIR. The other is shared by MIR and FIR. Each bank has a source register, a per-event mask register and a write-one-to-clear register.

The event pulses come from the link datapath. The active mode decides which bank a pulse lands in. The same event bit means different things in different modes. Bit 9 is receive timeout in SIR and abort detected in MIR/FIR. Bit 8 is framing error in SIR and CRC error in MIR/FIR. Software reads the source registers and clears bits by writing ones. A single registered interrupt output shows whether any unmasked event is pending in an unmasked group.

Register map (`wr_addr` / `rd_addr`): 0 transfer mode, 1 SIR source, 2 SIR mask, 3 SIR clear, 4 MIR/FIR source, 5 MIR/FIR mask, 6 MIR/FIR clear.

Top module: `ir_irq_ctrl`

## Requirements
- R1: After reset the transfer-mode register reads 0x0111 (mode 00, all three group masks set). Both mask registers read 0x8B80, both source registers read 0, and `irq` is 0.
- R2: In the transfer-mode register (address 0), bits 15:14 hold the mode: 00 SIR, 11 MIR, 10 FIR. Bit 8 masks the FIFO receive group, bit 4 masks the MIR/FIR group and bit 0 masks the SIR group. All other bits read 0, so writing 0xFFFF reads back 0xC111.
- R3: Each `ev_pulse` line maps to one bit of a source register. Index 4 is frame receive end (bit 15). Index 3 is transfer-area overflow (bit 11). Index 2 is bit 9: timeout in SIR, abort in MIR/FIR. Index 1 is bit 8: framing error in SIR, CRC error in MIR/FIR. Index 0 is frame transmit end (bit 7). All other source bits read 0.
- R4: When mode bit 15 is 1 (MIR or FIR), a pulse is recorded in the MIR/FIR source register (address 4). Otherwise it is recorded in the SIR source register (address 1). This includes the idle mode 00 and the unused code 01.
- R5: A source bit stays set until it is cleared. Writing 1 to a bit of a clear register (address 3 or 6) clears the matching source bit. Writing 0 leaves the bit unchanged.
- R6: If an event pulse and a clear write hit the same bit in the same cycle, the bit stays set.
- R7: `irq` is a registered level. It is the OR, over both banks, of source AND NOT event mask AND NOT the bank's group mask. It changes one clock edge after the source bit or mask that causes the change.
- R8: A mask bit of 1 keeps its event out of `irq`. The event is still recorded in the source register.
- R9: The SIR group mask (bit 0) gates only the SIR bank and the MIR/FIR group mask (bit 4) gates only the MIR/FIR bank. Events left pending in a bank still count after the mode changes. The FIFO receive group mask (bit 8) is stored but gates neither bank.
- R10: Reading a register has no side effect: source bits keep their value across reads. Clear registers read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (3) | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | AW (3) | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| ev_pulse | input | 5 | One-cycle event pulses from the link logic |
| irq | output | 1 | Registered interrupt level |

## Verification
A table of mode, mask and event patterns checks how events are steered and gated. It separates the two banks, the per-event masks and the group masks. It includes the unused mode code and an all-events burst with every mask set. Directed cases cover the reset values, the one-edge latency of `irq`, partial clears and zero writes, and an event colliding with a clear. They also cover repeated reads and mode changes while events are still pending. The mode-change case shows that a pending event keeps its bank, and that the FIFO group bit gates nothing.

// File: rtl/ir_irq_pkg.sv
package ir_irq_pkg;
  localparam int REG_W = 16;
  localparam int EV_N  = 5;

  localparam int MD_LO_BIT    = 14;
  localparam int GRP_FIFO_BIT = 8;
  localparam int GRP_MF_BIT   = 4;
  localparam int GRP_SIR_BIT  = 0;

  localparam logic [REG_W-1:0] EV_FIELD   = 16'h8B80;
  localparam logic [REG_W-1:0] MODE_FIELD = 16'hC111;

  typedef enum logic [1:0] {
    XM_SIR  = 2'b00,
    XM_RSVD = 2'b01,
    XM_FIR  = 2'b10,
    XM_MIR  = 2'b11
  } xmode_e;

  typedef enum logic [2:0] {
    RA_MODE = 3'd0,
    RA_SSRC = 3'd1,
    RA_SMSK = 3'd2,
    RA_SCLR = 3'd3,
    RA_MSRC = 3'd4,
    RA_MMSK = 3'd5,
    RA_MCLR = 3'd6
  } reg_addr_e;

  // register bit that carries compact event index k
  function automatic int ev_pos(input int k);
    case (k)
      0:       return 7;
      1:       return 8;
      2:       return 9;
      3:       return 11;
      default: return 15;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] ev_spread(input logic [EV_N-1:0] e);
    logic [REG_W-1:0] r;
    r = '0;
    for (int k = 0; k < EV_N; k++) r[ev_pos(k)] = e[k];
    return r;
  endfunction

  function automatic logic [EV_N-1:0] ev_gather(input logic [REG_W-1:0] w);
    logic [EV_N-1:0] r;
    for (int k = 0; k < EV_N; k++) r[k] = w[ev_pos(k)];
    return r;
  endfunction

  // 1 selects the MIR/FIR bank
  function automatic logic bank_of_mode(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/ir_mode_reg.sv
module ir_mode_reg
  import ir_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [REG_W-1:0] wr_data,
  output logic [1:0]       mode_q,
  output logic             grp_fifo_q,
  output logic             grp_mf_q,
  output logic             grp_sir_q,
  output logic [REG_W-1:0] view
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= XM_SIR;
      grp_fifo_q <= 1'b1;
      grp_mf_q   <= 1'b1;
      grp_sir_q  <= 1'b1;
    end else if (wr_stb) begin
      mode_q     <= wr_data[MD_LO_BIT +: 2];
      grp_fifo_q <= wr_data[GRP_FIFO_BIT];
      grp_mf_q   <= wr_data[GRP_MF_BIT];
      grp_sir_q  <= wr_data[GRP_SIR_BIT];
    end
  end

  always_comb begin
    view                  = '0;
    view[MD_LO_BIT +: 2]  = mode_q;
    view[GRP_FIFO_BIT]    = grp_fifo_q;
    view[GRP_MF_BIT]      = grp_mf_q;
    view[GRP_SIR_BIT]     = grp_sir_q;
  end
endmodule

// File: rtl/ir_evt_bank.sv
module ir_evt_bank #(
  parameter int NEV = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] ev_in,
  input  logic           msk_we,
  input  logic           clr_we,
  input  logic [NEV-1:0] wbits,
  output logic [NEV-1:0] src_q,
  output logic [NEV-1:0] msk_q,
  output logic           pend
);
  for (genvar i = 0; i < NEV; i++) begin : g_bit
    // source: event set wins over clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               src_q[i] <= 1'b0;
      else if (ev_in[i])        src_q[i] <= 1'b1;
      else if (clr_we && wbits[i]) src_q[i] <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      msk_q[i] <= 1'b1;
      else if (msk_we) msk_q[i] <= wbits[i];
    end
  end

  assign pend = |(src_q & ~msk_q);
endmodule

// File: rtl/ir_irq_out.sv
module ir_irq_out (
  input  logic clk,
  input  logic rst_n,
  input  logic pend_sir,
  input  logic pend_mf,
  input  logic grp_sir,
  input  logic grp_mf,
  output logic irq
);
  logic irq_d;
  assign irq_d = (pend_sir & ~grp_sir) | (pend_mf & ~grp_mf);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end
endmodule

// File: rtl/ir_irq_ctrl.sv
module ir_irq_ctrl
  import ir_irq_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [REG_W-1:0] rd_data,
  input  logic [EV_N-1:0]  ev_pulse,
  output logic             irq
);
  localparam int NBANK = 2;

  logic [1:0]       mode_q;
  logic             grp_fifo_q, grp_mf_q, grp_sir_q;
  logic [REG_W-1:0] mode_view;
  logic             sel_mf;
  logic [EV_N-1:0]  wbits;

  logic [EV_N-1:0]  bsrc  [NBANK];
  logic [EV_N-1:0]  bmsk  [NBANK];
  logic [EV_N-1:0]  bhit  [NBANK];
  logic             bpend [NBANK];

  // named views for the checker
  logic [EV_N-1:0]  sir_src_c, mf_src_c, sir_hit, mf_hit;

  ir_mode_reg u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb     (wr_en && (wr_addr == AW'(RA_MODE))),
    .wr_data    (wr_data),
    .mode_q     (mode_q),
    .grp_fifo_q (grp_fifo_q),
    .grp_mf_q   (grp_mf_q),
    .grp_sir_q  (grp_sir_q),
    .view       (mode_view)
  );

  assign sel_mf = bank_of_mode(mode_q);
  assign wbits  = ev_gather(wr_data);

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    localparam reg_addr_e MSK_A = (g == 0) ? RA_SMSK : RA_MMSK;
    localparam reg_addr_e CLR_A = (g == 0) ? RA_SCLR : RA_MCLR;
    localparam logic      IS_MF = (g == 1);

    assign bhit[g] = (sel_mf == IS_MF) ? ev_pulse : '0;

    ir_evt_bank #(.NEV(EV_N)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .ev_in  (bhit[g]),
      .msk_we (wr_en && (wr_addr == AW'(MSK_A))),
      .clr_we (wr_en && (wr_addr == AW'(CLR_A))),
      .wbits  (wbits),
      .src_q  (bsrc[g]),
      .msk_q  (bmsk[g]),
      .pend   (bpend[g])
    );
  end

  assign sir_src_c = bsrc[0];
  assign mf_src_c  = bsrc[1];
  assign sir_hit   = bhit[0];
  assign mf_hit    = bhit[1];

  ir_irq_out u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend_sir (bpend[0]),
    .pend_mf  (bpend[1]),
    .grp_sir  (grp_sir_q),
    .grp_mf   (grp_mf_q),
    .irq      (irq)
  );

  always_comb begin
    case (rd_addr)
      AW'(RA_MODE): rd_data = mode_view;
      AW'(RA_SSRC): rd_data = ev_spread(bsrc[0]);
      AW'(RA_SMSK): rd_data = ev_spread(bmsk[0]);
      AW'(RA_MSRC): rd_data = ev_spread(bsrc[1]);
      AW'(RA_MMSK): rd_data = ev_spread(bmsk[1]);
      default:      rd_data = '0;
    endcase
  end
endmodule

// File: rtl/ir_irq_ctrl_chk.sv
module ir_irq_ctrl_chk
  import ir_irq_pkg::*;
#(
  parameter int AW = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [AW-1:0]    wr_addr,
  input logic [REG_W-1:0] wr_data,
  input logic [EV_N-1:0]  ev_pulse,
  input logic             irq,
  input logic [1:0]       mode_q,
  input logic             grp_sir,
  input logic             grp_mf,
  input logic [EV_N-1:0]  sir_src_c,
  input logic [EV_N-1:0]  mf_src_c,
  input logic [EV_N-1:0]  sir_hit,
  input logic [EV_N-1:0]  mf_hit
);
  // R6
  ev_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|sir_hit) |=> ((sir_src_c & $past(sir_hit)) == $past(sir_hit)));

  // R5
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(RA_SCLR))
      |=> ((sir_src_c & $past(ev_gather(wr_data) & ~sir_hit)) == '0));

  // R4
  steer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1] && !(wr_en && wr_addr == AW'(RA_SCLR))) |=> $stable(sir_src_c));

  // R4
  steer_mf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q[1] && !(wr_en && wr_addr == AW'(RA_MCLR))) |=> $stable(mf_src_c));

  // R7
  idle_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sir_src_c == '0 && mf_src_c == '0) |=> !irq);

  // R9
  grp_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_sir && grp_mf) |=> !irq);

  // R3
  one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sir_hit & mf_hit) == '0) && ((sir_hit | mf_hit) == ev_pulse));
endmodule

bind ir_irq_ctrl ir_irq_ctrl_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .ev_pulse  (ev_pulse),
  .irq       (irq),
  .mode_q    (mode_q),
  .grp_sir   (grp_sir_q),
  .grp_mf    (grp_mf_q),
  .sir_src_c (sir_src_c),
  .mf_src_c  (mf_src_c),
  .sir_hit   (sir_hit),
  .mf_hit    (mf_hit)
);

// File: tb/sim_ir_irq_ctrl.sv
module sim_ir_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [4:0]  ev = '0;
  logic        irq;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  ir_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ev_pulse(ev), .irq(irq)
  );

  localparam logic [2:0] A_MODE = 3'd0, A_SSRC = 3'd1, A_SMSK = 3'd2,
                         A_SCLR = 3'd3, A_MSRC = 3'd4, A_MMSK = 3'd5,
                         A_MCLR = 3'd6;

  // {mode, gsir, gmf, smsk, mmsk, evt, exp_irq, exp_ssrc, exp_msrc}
  localparam int NV = 9;
  localparam logic [29:0] VEC [NV] = '{
    30'b00_0_1_00000_11111_10000_1_10000_00000,
    30'b00_1_1_00000_00000_00100_0_00100_00000,
    30'b00_0_1_00100_00000_00100_0_00100_00000,
    30'b11_1_0_00000_00000_00010_1_00000_00010,
    30'b10_1_0_00000_11101_00010_1_00000_00010,
    30'b10_1_1_00000_00000_00001_0_00000_00001,
    30'b01_0_1_00000_00000_01000_1_01000_00000,
    30'b00_0_1_11111_00000_11111_0_11111_00000,
    30'b11_0_0_00000_00001_00001_0_00000_00001
  };

  // bench view of the event bit layout: 7, 8, 9, 11, 15
  function automatic logic [15:0] spread(input logic [4:0] e);
    logic [15:0] w;
    w = {e[4], 3'b000, e[3], 1'b0, e[2], e[1], e[0], 7'b0};
    return w;
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wreg(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_reg(input string tag, input logic [2:0] a, input logic [15:0] exp);
    rd_addr = a;
    #0.5;
    chk(tag, rd_data, exp);
  endtask

  initial begin
    #(4 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(); step(); step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    chk_reg("R1 mode", A_MODE, 16'h0111);
    chk_reg("R1 smsk", A_SMSK, 16'h8B80);
    chk_reg("R1 mmsk", A_MMSK, 16'h8B80);
    chk_reg("R1 ssrc", A_SSRC, 16'h0000);
    chk_reg("R1 msrc", A_MSRC, 16'h0000);
    chk("R1 irq", {15'b0, irq}, 16'h0000);
    // R10 clear register reads 0
    chk_reg("R10 sclr", A_SCLR, 16'h0000);

    // R2 unimplemented bits
    wreg(A_MODE, 16'hFFFF);
    chk_reg("R2 mode", A_MODE, 16'hC111);

    // table: R3 R4 R8 R9
    for (int i = 0; i < NV; i++) begin
      logic [29:0] v;
      v = VEC[i];
      wreg(A_MODE, {v[29:28], 5'b0, 1'b1, 3'b0, v[26], 3'b0, v[27]});
      wreg(A_SMSK, spread(v[25:21]));
      wreg(A_MMSK, spread(v[20:16]));
      wreg(A_SCLR, 16'hFFFF);
      wreg(A_MCLR, 16'hFFFF);
      ev = v[15:11];
      step();
      ev = '0;
      step();
      chk($sformatf("R7 R8 R9 vec%0d irq", i), {15'b0, irq}, {15'b0, v[10]});
      chk_reg($sformatf("R3 R4 vec%0d ssrc", i), A_SSRC, spread(v[9:5]));
      chk_reg($sformatf("R3 R4 vec%0d msrc", i), A_MSRC, spread(v[4:0]));
    end

    // R7 latency
    wreg(A_MODE, 16'h0110);
    wreg(A_SMSK, 16'h0000);
    wreg(A_SCLR, 16'hFFFF);
    wreg(A_MCLR, 16'hFFFF);
    step();
    ev = 5'b00001;
    step();
    ev = '0;
    chk_reg("R7 src first", A_SSRC, 16'h0080);
    chk("R7 irq lag", {15'b0, irq}, 16'h0000);
    step();
    chk("R7 irq set", {15'b0, irq}, 16'h0001);

    // R5 partial clear and zero write
    ev = 5'b11111;
    step();
    ev = '0;
    wreg(A_SCLR, 16'h0A00);
    chk_reg("R5 partial", A_SSRC, 16'h8180);
    wreg(A_SCLR, 16'h0000);
    chk_reg("R5 zero write", A_SSRC, 16'h8180);

    // R6 event beats clear
    wreg(A_SCLR, 16'h8000);
    chk_reg("R6 prep", A_SSRC, 16'h0180);
    ev = 5'b10000;
    wreg(A_SCLR, 16'h8000);
    ev = '0;
    chk_reg("R6 collide", A_SSRC, 16'h8180);

    // R10 reads leave sources alone
    chk_reg("R10 read1", A_SSRC, 16'h8180);
    step();
    chk_reg("R10 read2", A_SSRC, 16'h8180);
    chk_reg("R10 other", A_MSRC, 16'h0000);
    step();
    chk_reg("R10 read3", A_SSRC, 16'h8180);

    // R9 pending SIR events survive a switch to FIR
    wreg(A_MODE, 16'h8000);
    step();
    chk("R9 fir open", {15'b0, irq}, 16'h0001);
    wreg(A_MODE, 16'h8001);
    step();
    chk("R9 sir group", {15'b0, irq}, 16'h0000);
    wreg(A_MODE, 16'h8100);
    step();
    chk("R9 fifo group", {15'b0, irq}, 16'h0001);
    ev = 5'b00100;
    step();
    ev = '0;
    chk_reg("R4 fir steer", A_MSRC, 16'h0200);
    chk_reg("R4 sir kept", A_SSRC, 16'h8180);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule